// File: doc/BRIEF.md
# Write-Status Read Responder

This block is the read-side data selector of a byte-wide non-volatile memory model. On every read cycle it chooses the word placed on the data bus. While the write sequencer is idle, a read returns the array word that the surrounding model presents for the current address. While an internal programming cycle is running, the same read returns a status word. Its top bit is the complement of the most recently written byte's top bit when that byte's address is read. Its second-highest bit inverts once for every new read cycle. All lower bits are zero.

A read cycle is open while chip enable and output enable are both low, and it closes when either one goes high. The block drives an output-enable flag that the enclosing model uses for its tri-state buffer. When the sequencer reports that a write was refused because the part is protected, the complemented top bit is not produced. The other status bits behave normally. By default the data and the enable are registered, so they follow the bus pins one clock later.

Top module: `wstat_read_resp`

## Requirements
- R1: `dq_oe` is 1 in the clock after any cycle in which `ce_n` and `oe_n` are both 0, and 0 in the clock after any cycle in which either is 1; after reset it is 0.
- R2: While `dq_oe` is 0, `dq_out` is all zeros.
- R3: A read with `wr_busy` 0 returns `arr_data` unchanged on all 8 bits.
- R4: A read with `wr_busy` 1, `wr_blocked` 0 and `rd_addr` equal to `last_addr` returns bit 7 equal to the inverse of `last_msb`.
- R5: A read with `wr_busy` 1 at any address other than `last_addr` returns bit 7 equal to `arr_data[7]`.
- R6: During a read with `wr_busy` 1, bits 5 down to 0 of `dq_out` are zero.
- R7: Bit 6 of two consecutive read cycles taken with `wr_busy` 1 has opposite values. A read cycle starts on the clock where `ce_n` and `oe_n` are first seen both low.
- R8: Within one read cycle held over several clocks with `wr_busy` 1, bit 6 keeps the same value.
- R9: With `wr_busy` 1 and `wr_blocked` 1, a read of `last_addr` returns bit 7 equal to `arr_data[7]`, not the inverse of `last_msb`.
- R10: Once `wr_busy` returns to 0, the next read of `last_addr` returns `arr_data` on all bits, bit 7 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Address of the current read |
| arr_data | input | DATA_W | Array word stored at `rd_addr` |
| wr_busy | input | 1 | Internal programming cycle in progress |
| wr_blocked | input | 1 | Last write was refused by protection |
| last_addr | input | ADDR_W | Address of the last byte written |
| last_msb | input | 1 | Top bit of the last byte written |
| dq_out | output | DATA_W | Data word for the bus |
| dq_oe | output | 1 | Bus drive enable for the tri-state buffer |

## Verification
Faults in the read-start detector show up as bit 6 that either fails to invert between two busy reads or changes in the middle of a long read. Both are visible on the first read cycle after the fault. A wrong address match or a wrong protection gate changes bit 7 on the very next busy read of the affected address. The bench compares every clock of each read, and of the idle clock after it, against a queue of expected words. A fault therefore shows within one clock of the cycle it affects.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   typedef enum logic [1:0] {
      RSP_NONE   = 2'd0,
      RSP_ARRAY  = 2'd1,
      RSP_STATUS = 2'd2
   } rsp_sel_e;

   function automatic rsp_sel_e pick_source(input logic rd_act, input logic busy);
      if (!rd_act)
         return RSP_NONE;
      else if (busy)
         return RSP_STATUS;
      else
         return RSP_ARRAY;
   endfunction

endpackage

// File: rtl/wsr_cycle_det.sv
module wsr_cycle_det (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   output logic rd_act,
   output logic rd_start
);
   logic rd_q;

   assign rd_act   = ~ce_n & ~oe_n;
   assign rd_start = rd_act & ~rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_q <= 1'b0;
      else
         rd_q <= rd_act;
   end
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic tog_nxt
);
   logic tog_q;

   assign tog_nxt = adv ? ~tog_q : tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tog_q <= 1'b0;
      else
         tog_q <= tog_nxt;
   end
endmodule

// File: rtl/wsr_status_mux.sv
module wsr_status_mux
   import wsr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 17
) (
   input  logic              rd_act,
   input  logic              busy,
   input  logic              blocked,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic              last_msb,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              tog,
   output logic [DATA_W-1:0] word
);
   localparam int DP_BIT = DATA_W - 1;
   localparam int TB_BIT = DATA_W - 2;

   rsp_sel_e sel;
   logic     hit;
   logic     dp_val;

   assign sel    = pick_source(rd_act, busy);
   assign hit    = (addr == last_addr) & ~blocked;
   assign dp_val = hit ? ~last_msb : arr_data[DP_BIT];

   always_comb begin
      word = '0;
      case (sel)
         RSP_ARRAY:  word = arr_data;
         RSP_STATUS: begin
            word[DP_BIT] = dp_val;
            word[TB_BIT] = tog;
         end
         default:    word = '0;
      endcase
   end
endmodule

// File: rtl/wstat_read_resp.sv
module wstat_read_resp #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 17,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              wr_busy,
   input  logic              wr_blocked,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic              last_msb,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   localparam int DP_BIT = DATA_W - 1;
   localparam int TB_BIT = DATA_W - 2;
   localparam int RSV_W  = DATA_W - 2;

   if (DATA_W < 3) begin : g_bad_width
      $error("wstat_read_resp: DATA_W must be at least 3");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("wstat_read_resp: ADDR_W must be at least 1");
   end

   logic              rd_act;
   logic              rd_start;
   logic              tog;
   logic [DATA_W-1:0] word;

   wsr_cycle_det u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .rd_act   (rd_act),
      .rd_start (rd_start)
   );

   wsr_toggle u_tog (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (rd_start),
      .tog_nxt (tog)
   );

   wsr_status_mux #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_mux (
      .rd_act    (rd_act),
      .busy      (wr_busy),
      .blocked   (wr_blocked),
      .addr      (rd_addr),
      .last_addr (last_addr),
      .last_msb  (last_msb),
      .arr_data  (arr_data),
      .tog       (tog),
      .word      (word)
   );

   if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] dq_q;
      logic              oe_q;
      logic              busy_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dq_q   <= '0;
            oe_q   <= 1'b0;
            busy_q <= 1'b0;
         end else begin
            dq_q   <= word;
            oe_q   <= rd_act;
            busy_q <= wr_busy;
         end
      end

      assign dq_out = dq_q;
      assign dq_oe  = oe_q;

      // R1
      oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ce_n && !oe_n) |=> dq_oe);
      // R1
      oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ce_n || oe_n) |=> !dq_oe);
      // R2
      quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !dq_oe |-> (dq_out == '0));
      // R3
      array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ce_n && !oe_n && !wr_busy) |=> (dq_out == $past(arr_data)));
      // R4
      last_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ce_n && !oe_n && wr_busy && !wr_blocked && rd_addr == last_addr)
         |=> (dq_out[DP_BIT] == !$past(last_msb)));
      // R6
      rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dq_oe && busy_q) |-> (dq_out[RSV_W-1:0] == '0));
      // R8
      tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dq_oe && $past(dq_oe) && busy_q && $past(busy_q))
         |-> (dq_out[TB_BIT] == $past(dq_out[TB_BIT])));
   end else begin : g_comb
      assign dq_out = word;
      assign dq_oe  = rd_act;

      // R2
      quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !dq_oe |-> (dq_out == '0));
      // R6
      rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dq_oe && wr_busy) |-> (dq_out[RSV_W-1:0] == '0));
   end
endmodule

// File: tb/wstat_read_resp_tb.sv
`timescale 1ns/1ps
module wstat_read_resp_tb_top;
   localparam int DW = 8;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] arr_data = '0;
   logic          wr_busy = 1'b0;
   logic          wr_blocked = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic          last_msb = 1'b0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   always #2.5 clk = ~clk;

   wstat_read_resp #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
      .rd_addr(rd_addr), .arr_data(arr_data), .wr_busy(wr_busy),
      .wr_blocked(wr_blocked), .last_addr(last_addr), .last_msb(last_msb),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   typedef struct {
      int          due;
      logic [7:0]  exp;
      logic [7:0]  mask;
      logic        oe_exp;
      int          tmode;   // 0 none, 1 must differ, 2 must match
      bit          rec;
      string       req;
   } sb_item_t;

   sb_item_t sbq[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   logic prev_tog = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor
   always @(negedge clk) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
         sb_item_t it;
         it = sbq.pop_front();
         checks++;
         if (dq_oe !== it.oe_exp || ((dq_out & it.mask) !== (it.exp & it.mask))) begin
            fails++;
            $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h mask=%02h",
                     it.req, dq_oe, dq_out, it.oe_exp, it.exp, it.mask);
         end
         if (it.tmode == 1) begin
            checks++;
            if (dq_out[6] === prev_tog) begin
               fails++;
               $display("FAIL %s: bit6=%0b expected %0b", it.req, dq_out[6], ~prev_tog);
            end
         end else if (it.tmode == 2) begin
            checks++;
            if (dq_out[6] !== prev_tog) begin
               fails++;
               $display("FAIL %s: bit6=%0b expected %0b", it.req, dq_out[6], prev_tog);
            end
         end
         if (it.rec) prev_tog = dq_out[6];
      end
   end

   task automatic push(input logic [7:0] exp, input logic [7:0] mask, input logic oe,
                       input int tmode, input bit rec, input string req);
      sb_item_t it;
      it.due = cyc + 1; it.exp = exp; it.mask = mask; it.oe_exp = oe;
      it.tmode = tmode; it.rec = rec; it.req = req;
      sbq.push_back(it);
   endtask

   // one read cycle held for n clocks, then one idle clock
   task automatic rd(input logic [AW-1:0] a, input logic [7:0] arr, input logic busy,
                     input logic blk, input int n, input logic [7:0] exp,
                     input logic [7:0] mask, input int first_tmode, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ce_n = 1'b0; oe_n = 1'b0; rd_addr = a; arr_data = arr;
         wr_busy = busy; wr_blocked = blk;
         push(exp, mask, 1'b1, (k == 0) ? first_tmode : (busy ? 2 : 0), busy, req);
      end
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      push(8'h00, 8'hFF, 1'b0, 0, 1'b0, "R2 idle after read");
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : driver
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (dq_oe !== 1'b0 || dq_out !== 8'h00) begin
         fails++;
         $display("FAIL R1 reset: oe=%0b data=%02h expected oe=0 data=00", dq_oe, dq_out);
      end
      // R3 idle reads, several patterns
      rd(17'h00010, 8'hA5, 1'b0, 1'b0, 1, 8'hA5, 8'hFF, 0, "R3 idle read A5");
      rd(17'h1FFFF, 8'h3C, 1'b0, 1'b0, 2, 8'h3C, 8'hFF, 0, "R3 idle read 3C");
      // R1 only one enable low: no drive
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; push(8'h00, 8'hFF, 1'b0, 0, 1'b0, "R1 ce high");
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; push(8'h00, 8'hFF, 1'b0, 0, 1'b0, "R1 oe high");
      @(negedge clk); ce_n = 1'b1;
      // busy: last byte 0x5A at 0x100 (msb 0)
      last_addr = 17'h00100; last_msb = 1'b0;
      rd(17'h00100, 8'h5A, 1'b1, 1'b0, 1, 8'h80, 8'hBF, 0, "R4 R6 inverted msb");
      rd(17'h00100, 8'h5A, 1'b1, 1'b0, 1, 8'h80, 8'hBF, 1, "R7 toggle busy read 2");
      rd(17'h00101, 8'hFF, 1'b1, 1'b0, 1, 8'h80, 8'hBF, 1, "R5 other addr msb 1");
      rd(17'h00102, 8'h7F, 1'b1, 1'b0, 1, 8'h00, 8'hBF, 1, "R5 other addr msb 0");
      rd(17'h00100, 8'h5A, 1'b1, 1'b0, 4, 8'h80, 8'hBF, 1, "R8 long busy read");
      last_msb = 1'b1;
      rd(17'h00100, 8'hC3, 1'b1, 1'b0, 1, 8'h00, 8'hBF, 1, "R4 msb 1 inverted");
      // protected, refused write
      last_msb = 1'b0;
      rd(17'h00100, 8'h00, 1'b1, 1'b1, 1, 8'h00, 8'hBF, 1, "R9 blocked msb true");
      rd(17'h00100, 8'h80, 1'b1, 1'b1, 1, 8'h80, 8'hBF, 1, "R9 blocked msb true 1");
      // end of programming
      rd(17'h00100, 8'h5A, 1'b0, 1'b0, 1, 8'h5A, 8'hFF, 0, "R10 true data after busy");
      rd(17'h00100, 8'h5A, 1'b0, 1'b0, 2, 8'h5A, 8'hFF, 0, "R10 data stable");
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule